// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit signed product in the same cycle, with no clock and no state. It suits a datapath that wants an exact product without first widening both operands to 2N bits.

The work happens in two steps. First every partial-product bit is formed at once from one multiplier bit and one multiplicand bit. A bit is an AND of the two, except where exactly one of the pair is a sign bit: there it is a NAND. Then a chain of N adder rows sums the partial products. Each row adds one shifted multiplier-bit row into a running 2N-bit total. The total starts from a fixed correction word that has ones at bit N and bit 2N-1. Those two ones balance the complemented terms, so no row needs sign extension.

Top module: `bw_array_mult`

## Requirements
- R1: `prod` equals the exact signed product of `op_a` and `op_b` as a 2N-bit two's-complement value, for every pair of operands.
- R2: The block is purely combinational. `prod` follows a change of `op_a` or `op_b` with no clock edge.
- R3: The most negative operand times itself gives +2^(2N-2). For N=8 that is 16'h4000, with bit 2N-1 clear.
- R4: When either operand is zero, `prod` is zero.
- R5: When the product is nonzero, bit 2N-1 of `prod` equals the XOR of the two operand sign bits (bit N-1 of each).
- R6: Multiplying by +1 returns the other operand sign-extended to 2N bits. Multiplying by -1 (all ones) returns its 2N-bit negation, so the most negative operand gives +2^(N-1).
- R7: With N=5, -13 (5'b10011) times -15 (5'b10001) gives +195, which is 10'b0011000011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplier, two's complement; bit N-1 is the sign |
| op_b | input | N | Multiplicand, two's complement; bit N-1 is the sign |
| prod | output | 2N | Signed product, two's complement |

## Verification
Immediate assertions in the top module re-check every input change. They check that the product matches a signed reference multiply, that a zero operand gives zero, that a nonzero product carries the right sign, and that multiplying by one returns the other operand. Only the bench's scenarios can show the exact corner values. These are the square of the most negative operand, negation of the most negative operand and the fixed five-bit vector. The same goes for the combinational response without a clock edge and the spread of random operand pairs of every sign.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  typedef struct packed {
    logic cout;
    logic sum;
  } fa_res_t;

  // One full-adder cell: sum is the parity, carry is the majority.
  function automatic fa_res_t full_add(input logic x, input logic y, input logic cin);
    fa_res_t r;
    r.sum  = x ^ y ^ cin;
    r.cout = (x & y) | (x & cin) | (y & cin);
    return r;
  endfunction

  // Partial-product bit for multiplier bit i and multiplicand bit j.
  // It is complemented when exactly one of the two bits is a sign bit.
  function automatic logic pp_term(input logic ai, input logic bj,
                                   input bit i_is_sign, input bit j_is_sign);
    logic t;
    t = ai & bj;
    return (i_is_sign ^ j_is_sign) ? ~t : t;
  endfunction

endpackage

// File: rtl/bw_pp_gen.sv
module bw_pp_gen
  import bw_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]        mcand,
  input  logic [N-1:0]        mplier,
  output logic [N-1:0][N-1:0] rows
);

  // Row i holds the terms of weight i+j, for j = 0 .. N-1.
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign rows[i][j] = pp_term(mplier[i], mcand[j], (i == N-1), (j == N-1));
    end
  end

endmodule

// File: rtl/bw_row_adder.sv
module bw_row_adder
  import bw_mult_pkg::*;
#(
  parameter int N     = 8,
  parameter int SHIFT = 0
) (
  input  logic [2*N-1:0] acc_in,
  input  logic [N-1:0]   row,
  output logic [2*N-1:0] acc_out
);

  localparam int W    = 2 * N;
  localparam int SPAN = W - SHIFT;

  // Bits below SHIFT are never touched by this row.
  if (SHIFT > 0) begin : g_low
    assign acc_out[SHIFT-1:0] = acc_in[SHIFT-1:0];
  end

  // Ripple chain over the upper bits. The last carry falls off (mod 2^2N).
  logic [SPAN-1:0] upper;
  always_comb begin
    logic    c;
    fa_res_t r;
    c = 1'b0;
    for (int k = 0; k < SPAN; k++) begin
      r        = full_add(acc_in[SHIFT+k], (k < N) ? row[k] : 1'b0, c);
      upper[k] = r.sum;
      c        = r.cout;
    end
  end
  assign acc_out[W-1:SHIFT] = upper;

endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);

  localparam int W = 2 * N;
  // Correction ones at bit N and bit 2N-1 balance the complemented terms.
  localparam logic [W-1:0] CORR = (W'(1) << N) | (W'(1) << (W-1));

  logic [N-1:0][N-1:0] pp_rows;
  logic [W-1:0]        stage [N+1];

  bw_pp_gen #(.N(N)) u_pp (
    .mcand  (op_b),
    .mplier (op_a),
    .rows   (pp_rows)
  );

  assign stage[0] = CORR;

  for (genvar i = 0; i < N; i++) begin : g_sum
    bw_row_adder #(.N(N), .SHIFT(i)) u_row (
      .acc_in  (stage[i]),
      .row     (pp_rows[i]),
      .acc_out (stage[i+1])
    );
  end

  assign prod = stage[N];

  // Named observation wires for the checks below.
  logic [W-1:0] ref_prod;
  logic         a_zero, b_zero, a_one, b_one, sign_xor;
  assign ref_prod = W'($signed(op_a) * $signed(op_b));
  assign a_zero   = (op_a == '0);
  assign b_zero   = (op_b == '0);
  assign a_one    = (op_a == N'(1));
  assign b_one    = (op_b == N'(1));
  assign sign_xor = op_a[N-1] ^ op_b[N-1];

  always_comb begin
    AST_PRODUCT_MATCH: assert (prod == ref_prod); // R1
    AST_ZERO_ABSORB: assert (!(a_zero || b_zero) || prod == '0); // R4
    AST_SIGN_RULE: assert (prod == '0 || prod[W-1] == sign_xor); // R5
    AST_UNIT_PASS: assert (!b_one || prod == W'($signed(op_a))); // R6
  end

endmodule

// File: tb/bw_array_mult_test.sv
module bw_array_mult_test;

  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic [W-1:0] prod;

  logic [4:0] a5 = '0;
  logic [4:0] b5 = '0;
  logic [9:0] prod5;

  bw_array_mult #(.N(N)) uut (.op_a(op_a), .op_b(op_b), .prod(prod));
  bw_array_mult #(.N(5)) uut5 (.op_a(a5), .op_b(b5), .prod(prod5));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference: shift-and-add over sign-extended operands, kept mod 2^W.
  function automatic logic [W-1:0] exp_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [W-1:0] ea, eb, acc;
    ea  = {{N{a[N-1]}}, a};
    eb  = {{N{b[N-1]}}, b};
    acc = '0;
    for (int k = 0; k < W; k++)
      if (eb[k]) acc = acc + (ea << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    op_a = a;
    op_b = b;
    #2;
    check(req, prod, exp_mul(a, b));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] ra, rb;
    logic [31:0]  seed_val;
    #3;
    check("R4 idle zero", prod, '0);

    // R3: most negative squared
    apply(8'h80, 8'h80, "R3");
    check("R3 value", prod, 16'h4000);

    // R4: zero absorbs
    apply(8'h00, 8'h7F, "R4");
    apply(8'h80, 8'h00, "R4");

    // R6: +1 and -1
    apply(8'h01, 8'h93, "R6");
    apply(8'hA5, 8'h01, "R6");
    apply(8'hFF, 8'h80, "R6");
    check("R6 neg of min", prod, 16'h0080);
    apply(8'h37, 8'hFF, "R6");
    check("R6 neg", prod, 16'hFFC9);

    // R5: sign patterns
    apply(8'h7F, 8'h81, "R5");
    check("R5 sign", {15'd0, prod[W-1]}, 16'd1);
    apply(8'h85, 8'h83, "R5");
    check("R5 sign", {15'd0, prod[W-1]}, 16'd0);

    // R2: output follows input changes without a clock edge
    @(negedge clk);
    op_a = 8'h0C; op_b = 8'h0B;
    #1;
    check("R2 no edge", prod, 16'd132);
    op_b = 8'hF5;
    #1;
    check("R2 no edge", prod, 16'hFF7C);

    // R7: five-bit vector
    a5 = 5'b10011; b5 = 5'b10001;
    #2;
    checks++;
    if (prod5 !== 10'b0011000011) begin
      errors++;
      $display("FAIL R7: actual=%b expected=%b", prod5, 10'b0011000011);
    end

    // R1: random pairs from a fixed seed
    seed_val = $urandom(32'd20240611);
    for (int n = 0; n < 400; n++) begin
      ra = N'($urandom);
      rb = N'($urandom);
      if (n % 16 == 0) ra = {1'b1, {(N-1){1'b0}}};
      if (n % 16 == 1) rb = {N{1'b1}};
      apply(ra, rb, "R1 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule